// File: doc/BRIEF.md
# Cell Transmit Port with Nibble Mode

This block is the drain side of one channel of a cell-oriented FIFO. It reads 9-bit words from a local first-word-fall-through buffer and places them on a cell transmit interface. That interface has a data bus, a start-of-cell flag, a cell-available input from the receiver and an active-low transfer enable. A cell is a fixed run of words. The port opens a cell only when the buffer holds a complete cell and the receiver reports room. Once a cell is open, the port finishes it.

Two static selects shape the transfer. The width select picks between two forms. In the first, each whole word goes out in a single transfer. In the second, each word is split into a low nibble and a high nibble, and spare bus lines carry the remaining bits. The role select makes the port either a master or a slave. As a master, it paces the transfers itself and announces each one on its enable output. As a slave, it advances one transfer for every clock edge at which the downstream side holds the enable input low. Both selects are taken only between cells.

Top module: `tx_port`

## Requirements
- R1: After reset, tx_data is all zeros, tx_soc is low, tx_en_n_out is high and buf_pop is low.
- R2: A cell starts only at a clock edge where buf_level is at least CELL_WORDS (53) and tx_cav is high. In slave role, tx_en_n_in must also be low at that edge. Otherwise the port transfers nothing and pops nothing.
- R3: In master role, the first transfer appears at the edge where the start condition holds. After that, the cell moves one transfer per clock without a gap until it is complete, whatever tx_cav does. tx_en_n_out is low exactly in the cycles that carry a transfer.
- R4: In wide mode (cfg_wide=1), each transfer puts a whole buffer word on tx_data[8:0]. Each transfer pops one word, so a cell takes CELL_WORDS transfers.
- R5: In nibble mode (cfg_wide=0), each word goes out in two transfers: bits 3:0 first, then bits 7:4, both on tx_data[3:0]. tx_data[8] carries the word's bit 8 in both transfers, and tx_data[6:4] are 0. The word is popped with its high-nibble transfer, so a cell takes 2*CELL_WORDS transfers.
- R6: In master nibble mode, tx_data[7] acts as an output enable for the downstream device. It is 1 in every transfer cycle and 0 in every cycle without a transfer. tx_data holds its other lines between transfers.
- R7: In slave role, every clock edge with tx_en_n_in low during a cell presents the next transfer. With tx_en_n_in high, tx_data and tx_soc hold. tx_en_n_out stays high, and in nibble mode tx_data[7] is 0.
- R8: tx_soc is 1 with the first transfer of each cell and 0 with every later transfer of that cell. In master role it is also 0 in cycles without a transfer.
- R9: cfg_wide and cfg_master are taken only at the edge that starts a cell, so a change during a cell has no effect on that cell. When a second complete cell is buffered and tx_cav is high, the next cell starts at the edge right after the last transfer, using the select values present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers occur on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 = whole-word transfers, 0 = two nibble transfers per word |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| buf_level | input | LVL_W (8) | Number of words currently held in the buffer |
| buf_word | input | 9 | Head word of the buffer (first-word-fall-through) |
| buf_pop | output | 1 | Removes the head word at the next rising edge |
| tx_data | output | 9 | Transmit data bus |
| tx_soc | output | 1 | Start-of-cell marker |
| tx_cav | input | 1 | Receiver can accept a cell |
| tx_en_n_in | input | 1 | Slave role: active-low request to advance one transfer |
| tx_en_n_out | output | 1 | Master role: active-low, marks a transfer in this cycle |

## Verification
Two events can meet at the boundary between cells. One is the closing transfer of a cell, which pops the buffer's last word of that cell. The other is the start test for the next cell, which reads the level that pop has just lowered to exactly one cell, along with the select values changed while the first cell was running. The bench buffers two cells and keeps tx_cav high. It flips cfg_wide during the first cell. It then expects one unbroken stream: 53 whole-word transfers followed by 106 nibble transfers, with tx_soc set only at transfers 0 and 53, and the buffer left empty.

// File: rtl/tx_port_pkg.sv
package tx_port_pkg;

    // Sequencer state: between cells, or inside a cell
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/tx_seq.sv
module tx_seq
    import tx_port_pkg::*;
#(
    parameter int CELL_WORDS = 53,
    parameter int LVL_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic             cfg_master,
    input  logic [LVL_W-1:0] buf_level,
    input  logic             tx_cav,
    input  logic             tx_en_n_in,
    output logic             launch,
    output logic             first,
    output logic             hi_phase,
    output logic             eff_wide,
    output logic             eff_master,
    output logic             pop,
    output logic             busy
);

    localparam int IDX_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);
    localparam logic [LVL_W-1:0] CELL_LVL = LVL_W'(CELL_WORDS);

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] idx;     // word index inside the cell
        logic             hi;      // next transfer is a high nibble
        logic             wide;    // width select taken at cell start
        logic             master;  // role select taken at cell start
    } seq_t;

    seq_t seq_d, seq_q;

    logic idle, room, go, word_done, cell_done;

    always_comb begin
        seq_d      = seq_q;
        idle       = (seq_q.st == ST_IDLE);
        eff_wide   = idle ? cfg_wide   : seq_q.wide;
        eff_master = idle ? cfg_master : seq_q.master;
        room       = tx_cav && (buf_level >= CELL_LVL);
        go         = eff_master || !tx_en_n_in;
        launch     = go && (!idle || room);
        first      = idle;
        hi_phase   = seq_q.hi;
        word_done  = eff_wide || seq_q.hi;
        cell_done  = word_done && (seq_q.idx == LAST_IDX);
        pop        = launch && word_done;
        busy       = !idle;

        if (launch) begin
            if (idle) begin
                seq_d.wide   = cfg_wide;
                seq_d.master = cfg_master;
            end
            if (cell_done) begin
                seq_d.st  = ST_IDLE;
                seq_d.idx = '0;
                seq_d.hi  = 1'b0;
            end else begin
                seq_d.st = ST_SEND;
                if (word_done) begin
                    seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.hi  = 1'b0;
                end else begin
                    seq_d.hi = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, idx: '0, hi: 1'b0, wide: 1'b1, master: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/tx_lane.sv
module tx_lane #(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 first,
    input  logic                 hi_phase,
    input  logic                 eff_wide,
    input  logic                 eff_master,
    input  logic [2*NIB_W:0]     word,
    output logic [2*NIB_W:0]     tx_data,
    output logic                 tx_soc,
    output logic                 tx_en_n
);

    localparam int WORD_W = 2 * NIB_W + 1;
    localparam logic [WORD_W-1:0] OE_MASK = {1'b0, 1'b1, {(WORD_W-2){1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              soc;
        logic              en_n;
        logic              oe;    // downstream output enable on the spare line
    } lane_t;

    lane_t lane_d, lane_q;
    logic [WORD_W-1:0] nib_bus, lane_bus;

    always_comb begin
        nib_bus              = '0;
        nib_bus[NIB_W-1:0]   = hi_phase ? word[2*NIB_W-1:NIB_W] : word[NIB_W-1:0];
        nib_bus[WORD_W-1]    = word[WORD_W-1];
        lane_bus             = eff_wide ? word : nib_bus;

        lane_d = lane_q;
        if (eff_master) begin
            lane_d.en_n = !launch;
            lane_d.soc  = launch && first;
            lane_d.oe   = launch && !eff_wide;
            if (launch) begin
                lane_d.data = lane_bus;
            end
        end else begin
            lane_d.en_n = 1'b1;
            lane_d.oe   = 1'b0;
            if (launch) begin
                lane_d.data = lane_bus;
                lane_d.soc  = first;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '{data: '0, soc: 1'b0, en_n: 1'b1, oe: 1'b0};
        end else begin
            lane_q <= lane_d;
        end
    end

    assign tx_data = lane_q.data | (lane_q.oe ? OE_MASK : '0);
    assign tx_soc  = lane_q.soc;
    assign tx_en_n = lane_q.en_n;

endmodule

// File: rtl/tx_port.sv
module tx_port #(
    parameter int NIB_W      = 4,
    parameter int CELL_WORDS = 53,
    parameter int LVL_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic               cfg_master,
    input  logic [LVL_W-1:0]   buf_level,
    input  logic [2*NIB_W:0]   buf_word,
    output logic               buf_pop,
    output logic [2*NIB_W:0]   tx_data,
    output logic               tx_soc,
    input  logic               tx_cav,
    input  logic               tx_en_n_in,
    output logic               tx_en_n_out
);

    logic seq_launch, seq_first, seq_hi, seq_wide, seq_master, seq_busy;

    tx_seq #(
        .CELL_WORDS (CELL_WORDS),
        .LVL_W      (LVL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wide   (cfg_wide),
        .cfg_master (cfg_master),
        .buf_level  (buf_level),
        .tx_cav     (tx_cav),
        .tx_en_n_in (tx_en_n_in),
        .launch     (seq_launch),
        .first      (seq_first),
        .hi_phase   (seq_hi),
        .eff_wide   (seq_wide),
        .eff_master (seq_master),
        .pop        (buf_pop),
        .busy       (seq_busy)
    );

    tx_lane #(
        .NIB_W (NIB_W)
    ) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (seq_launch),
        .first      (seq_first),
        .hi_phase   (seq_hi),
        .eff_wide   (seq_wide),
        .eff_master (seq_master),
        .word       (buf_word),
        .tx_data    (tx_data),
        .tx_soc     (tx_soc),
        .tx_en_n    (tx_en_n_out)
    );

endmodule

// File: rtl/tx_port_chk.sv
module tx_port_chk #(
    parameter int CELL_WORDS = 53,
    parameter int LVL_W      = 8,
    parameter int WORD_W     = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  buf_level,
    input logic              buf_pop,
    input logic [WORD_W-1:0] tx_data,
    input logic              tx_soc,
    input logic              tx_cav,
    input logic              tx_en_n_in,
    input logic              tx_en_n_out,
    input logic              busy,
    input logic              cur_master
);

    localparam logic [LVL_W-1:0] CELL_LVL = LVL_W'(CELL_WORDS);

    // R2: the first pop of a cell needs a whole cell buffered and room downstream
    a_r2_start_needs_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_pop && !busy) |-> (tx_cav && (buf_level >= CELL_LVL)));

    // R3: a master cell in progress keeps transferring every clock
    a_r3_master_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_master) |=> !tx_en_n_out);

    // R4: never pop an empty buffer
    a_r4_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop |-> (buf_level != '0));

    // R7: a slave with no request holds its bus
    a_r7_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_master && tx_en_n_in) |=> ($stable(tx_data) && $stable(tx_soc)));

    // R7: a slave never drives its enable output low
    a_r7_slave_en_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cur_master) |=> tx_en_n_out);

    // R8: a start-of-cell transfer in master role is followed by a cleared marker
    a_r8_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_soc && !tx_en_n_out) |=> !tx_soc);

endmodule

bind tx_port tx_port_chk #(
    .CELL_WORDS (CELL_WORDS),
    .LVL_W      (LVL_W),
    .WORD_W     (2 * NIB_W + 1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_level   (buf_level),
    .buf_pop     (buf_pop),
    .tx_data     (tx_data),
    .tx_soc      (tx_soc),
    .tx_cav      (tx_cav),
    .tx_en_n_in  (tx_en_n_in),
    .tx_en_n_out (tx_en_n_out),
    .busy        (seq_busy),
    .cur_master  (seq_master)
);

// File: tb/test_tx_port.sv
module test_tx_port;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 53;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wide = 1'b1;
    logic       cfg_master = 1'b1;
    logic [7:0] buf_level;
    logic [8:0] buf_word;
    logic       buf_pop;
    logic [8:0] tx_data;
    logic       tx_soc;
    logic       tx_cav = 1'b0;
    logic       tx_en_n_in = 1'b1;
    logic       tx_en_n_out;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // buffer model: words written by the stimulus, popped by the port
    logic [8:0] mem [0:255];
    logic [7:0] wptr = 8'd0;
    logic [7:0] rptr;
    assign buf_level = wptr - rptr;
    assign buf_word  = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) rptr <= 8'd0;
        else if (buf_pop) rptr <= rptr + 8'd1;
    end

    tx_port i_tx_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wide    (cfg_wide),
        .cfg_master  (cfg_master),
        .buf_level   (buf_level),
        .buf_word    (buf_word),
        .buf_pop     (buf_pop),
        .tx_data     (tx_data),
        .tx_soc      (tx_soc),
        .tx_cav      (tx_cav),
        .tx_en_n_in  (tx_en_n_in),
        .tx_en_n_out (tx_en_n_out)
    );

    typedef struct packed {
        logic [7:0] seed;
        logic [1:0] ncells;
        logic       w0;      // width select at cell start
        logic       w1;      // width select applied after first transfer
        logic       master;
    } row_t;

    localparam row_t ROWS [5] = '{
        '{8'd3,  2'd1, 1'b1, 1'b0, 1'b1},   // master wide, select flipped mid-cell
        '{8'd5,  2'd1, 1'b0, 1'b1, 1'b1},   // master nibble, select flipped mid-cell
        '{8'd9,  2'd2, 1'b1, 1'b0, 1'b1},   // back-to-back, second cell nibble
        '{8'd11, 2'd1, 1'b1, 1'b0, 1'b0},   // slave wide
        '{8'd13, 2'd1, 1'b0, 1'b1, 1'b0}    // slave nibble
    };

    function automatic logic [8:0] wv(input int seed, input int i);
        return 9'((seed * 41 + i * 73 + (i >> 2)) & 511);
    endfunction

    // {soc, data} expected for transfer t of a run
    function automatic logic [9:0] exp_of(input int seed, input bit w0, input bit w1,
                                          input bit master, input int t);
        int cnt0, c, tt, i;
        bit wide, hi;
        logic [8:0] w, d;
        cnt0 = w0 ? CW : 2 * CW;
        c    = (t < cnt0) ? 0 : 1;
        tt   = (c == 0) ? t : t - cnt0;
        wide = (c == 0) ? w0 : w1;
        i    = wide ? tt : tt / 2;
        hi   = wide ? 1'b0 : bit'(tt % 2);
        w    = wv(seed + c, i);
        d    = wide ? w : {w[8], master, 3'b000, hi ? w[7:4] : w[3:0]};
        return {(tt == 0), d};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_words(input int seed, input int from, input int n);
        for (int i = 0; i < n; i++) begin
            mem[wptr] = wv(seed, from + i);
            wptr      = wptr + 8'd1;
        end
    endtask

    task automatic run_master(input int seed, input int nc, input bit w0, input bit w1);
        int total, t, first_cyc, last_cyc, idle_cnt;
        int d_err, s_err, q_err, d_act, d_exp;
        logic [9:0] e;
        total = (w0 ? CW : 2 * CW) + ((nc == 2) ? (w1 ? CW : 2 * CW) : 0);
        t = 0; first_cyc = -1; last_cyc = -1; idle_cnt = 0;
        d_err = 0; s_err = 0; q_err = 0; d_act = 0; d_exp = 0;
        cfg_master = 1'b1;
        cfg_wide   = w0;
        tx_cav     = 1'b1;
        for (int cyc = 0; cyc < 600 && idle_cnt < 4; cyc++) begin
            @(negedge clk);
            if (!tx_en_n_out) begin
                e = exp_of(seed, w0, w1, 1'b1, t);
                if (t >= total || tx_data !== e[8:0]) begin
                    if (d_err == 0) begin d_act = int'(tx_data); d_exp = int'(e[8:0]); end
                    d_err++;
                end
                if (t < total && tx_soc !== e[9]) s_err++;
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                t++;
                if (t == 1) begin
                    cfg_wide = w1;
                    if (nc == 1) tx_cav = 1'b0;
                end
            end else begin
                if (tx_soc !== 1'b0) s_err++;
                if (!((nc == 2) ? w1 : w0) && tx_data[7] !== 1'b0) q_err++;
                if (t >= total) idle_cnt++;
            end
        end
        tx_cav = 1'b0;
        check(t == total, "R3", "master transfer count", t, total);
        check(last_cyc - first_cyc == total - 1, "R3", "master transfers contiguous",
              last_cyc - first_cyc, total - 1);
        check(d_err == 0, w0 ? "R4" : "R5", "master data word", d_act, d_exp);
        check(s_err == 0, "R8", "master start-of-cell marks", s_err, 0);
        check(q_err == 0, "R6", "line 7 low without transfer", q_err, 0);
        check(buf_level == 8'd0, "R4", "words popped for run", int'(buf_level), 0);
        if (nc == 2) check(d_err == 0 && t == total, "R9", "second cell uses new width", t, total);
        if (nc == 1) check(d_err == 0, "R9", "mid-cell select change ignored", d_err, 0);
    endtask

    task automatic run_slave(input int seed, input bit w0, input bit w1);
        int total, t, after, d_err, h_err, e_err, s_err, d_act, d_exp;
        bit prev_low;
        logic [8:0] last_d;
        logic [9:0] e;
        total = w0 ? CW : 2 * CW;
        t = 0; after = 0; d_err = 0; h_err = 0; e_err = 0; s_err = 0;
        d_act = 0; d_exp = 0; prev_low = 1'b0;
        cfg_master = 1'b0;
        cfg_wide   = w0;
        tx_cav     = 1'b1;
        @(negedge clk);
        last_d = tx_data;
        for (int cyc = 0; cyc < 900 && after < 6; cyc++) begin
            @(negedge clk);
            if (prev_low && t < total) begin
                e = exp_of(seed, w0, w1, 1'b0, t);
                if (tx_data !== e[8:0]) begin
                    if (d_err == 0) begin d_act = int'(tx_data); d_exp = int'(e[8:0]); end
                    d_err++;
                end
                if (tx_soc !== e[9]) s_err++;
                last_d = tx_data;
                t++;
                if (t == 1) begin cfg_wide = w1; tx_cav = 1'b0; end
            end else begin
                if (tx_data !== last_d) h_err++;
                if (t >= total) after++;
            end
            if (tx_en_n_out !== 1'b1) e_err++;
            tx_en_n_in = (cyc % 3 == 2);
            prev_low   = !tx_en_n_in;
        end
        tx_en_n_in = 1'b1;
        tx_cav     = 1'b0;
        check(t == total, "R7", "slave transfer count", t, total);
        check(d_err == 0, w0 ? "R4" : "R5", "slave data word", d_act, d_exp);
        check(h_err == 0, "R7", "slave hold without request", h_err, 0);
        check(e_err == 0, "R7", "slave enable output high", e_err, 0);
        check(s_err == 0, "R8", "slave start-of-cell marks", s_err, 0);
        check(buf_level == 8'd0, "R9", "slave cell fully drained", int'(buf_level), 0);
    endtask

    task automatic quiet_cycles(input int n, input string req, input string what);
        int bad;
        logic [8:0] d0;
        bad = 0;
        @(negedge clk);
        d0 = tx_data;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_en_n_out !== 1'b1 || buf_pop !== 1'b0 || tx_data !== d0) bad++;
        end
        check(bad == 0, req, what, bad, 0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_data == 9'd0, "R1", "data after reset", int'(tx_data), 0);
        check(tx_soc == 1'b0, "R1", "soc after reset", int'(tx_soc), 0);
        check(tx_en_n_out == 1'b1, "R1", "enable after reset", int'(tx_en_n_out), 1);
        check(buf_pop == 1'b0, "R1", "pop after reset", int'(buf_pop), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: one word short of a cell, room downstream: no start
        cfg_master = 1'b1; cfg_wide = 1'b1;
        push_words(21, 0, CW - 1);
        tx_cav = 1'b1;
        quiet_cycles(8, "R2", "no start with partial cell");
        push_words(21, CW - 1, 1);
        run_master(21, 1, 1'b1, 1'b1);

        // R2: whole cell buffered but receiver full: no start
        push_words(23, 0, CW);
        tx_cav = 1'b0;
        quiet_cycles(8, "R2", "no start without cell-available");
        run_master(23, 1, 1'b0, 1'b0);

        // R2/R7: slave with cell and room but no request: no start
        push_words(25, 0, CW);
        cfg_master = 1'b0; tx_cav = 1'b1; tx_en_n_in = 1'b1;
        quiet_cycles(8, "R7", "slave idle without request");
        run_slave(25, 1'b0, 1'b0);

        // table of runs
        for (int r = 0; r < 5; r++) begin
            for (int c = 0; c < int'(ROWS[r].ncells); c++)
                push_words(int'(ROWS[r].seed) + c, 0, CW);
            if (ROWS[r].master)
                run_master(int'(ROWS[r].seed), int'(ROWS[r].ncells), ROWS[r].w0, ROWS[r].w1);
            else
                run_slave(int'(ROWS[r].seed), ROWS[r].w0, ROWS[r].w1);
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule